// File: doc/BRIEF.md
# Microprogrammed Control Address Sequencer

This block is the sequencing core of a microprogrammed controller. A 6-bit microaddress register selects one 26-bit control word from an internal control store. Number the word's bits C1 to C26, with C1 at bit 0. C1..C6 hold a next-address literal. C7..C26 are single command bits. Four of the command bits steer the sequencer itself:

- C23 increments the microaddress.
- C24 jumps to the literal.
- C25 dispatches to opcode + microaddress + 1.
- C26 returns to zero.

C21 loads an internal opcode register from the opcode bits of the memory buffer. The sixteen bits C7..C22 are presented to the datapath as plain control outputs.

The control store is read combinationally from the current microaddress, so the commands for a microaddress are valid during the same cycle. The microaddress and the opcode register change on the rising clock edge. The control store image is built from parameters at elaboration time. The datapath that acts on the commands lies outside this block. All pins are plain control and status pins; there is no streamed data and so no handshake.

Top module: `useq_core`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `upc` is 0 and `opcode` is 0.
- R2: A word with only C23 among C23..C26 advances `upc` by one at the next rising edge.
- R3: `opcode` takes the value of `mem_opcode` at a rising edge only if the current word has C21 set. Otherwise it keeps its value, whatever `mem_opcode` does.
- R4: A word with C25 (and neither C26 nor C24) loads `upc` with (`opcode` + `upc` + 1) modulo 64.
- R5: A word with C24 (and not C26) loads `upc` with its C1..C6 literal.
- R6: A word with C26 loads `upc` with 0.
- R7: When several of C23..C26 are set, the priority is C26 first, then C24, then C25, then C23.
- R8: A word with none of C23..C26 set leaves `upc` unchanged.
- R9: `dp_cmd[i]` equals command C(i+7) of the word at the current `upc`, in the same cycle.
- R10: The dispatch sum wraps modulo 64. With `opcode` 62 at address 2, the sequencer goes to address 1.
- R11: The default image, with jump target T = 20, is as follows. Any address not listed holds a zero word.

| Address | Commands set | Effect |
|---|---|---|
| 0 | C15 + C23 | |
| 1 | C21 + C23 | |
| 2 | C25 | dispatch |
| 3 | C24, literal T | |
| 4 | C12 + C24, literal 0 | |
| 5 | C22 + C23 | |
| 6 | C14 + C26 + C24, literal 30 | |
| 7 | C24, literal 9, + C25 + C23 | |
| 8 | C25 + C23 | |
| 9 | C8 | hold |
| 14 | C9 + C26 | |
| T | C10 + C23 | |
| T+1 | C11 + C23 | |
| T+2 | C13 + C26 | |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_opcode | input | 6 | Opcode bits of the memory buffer |
| dp_cmd | output | 16 | Datapath commands C7..C22 of the current word |
| upc | output | 6 | Current microaddress |
| opcode | output | 6 | Opcode register contents |

## Verification
The `dp_cmd` outputs are combinational from `upc`, so they are due in the cycle a word is addressed. A new `upc` is due one rising edge after the word that chose it. The opcode register loads at the edge that ends address 1, and its effect on `upc` appears one edge after address 2. The bench drives inputs and samples every output at the falling edge that follows each rising edge, so each check sees exactly one register update. Directed scenarios walk the default image from reset. Together they cover each sequencing path, each priority pair, the hold word and the wrap.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int CW_W   = 26;
  localparam int LIT_W  = 6;
  localparam int DP_LO  = 6;
  localparam int DP_W   = 16;
  localparam int B_OPLD = 20;
  localparam int B_INC  = 22;
  localparam int B_LIT  = 23;
  localparam int B_DISP = 24;
  localparam int B_CLR  = 25;

  typedef logic [CW_W-1:0] cword_t;

  function automatic cword_t cbit(input int n);
    cword_t w;
    w = '0;
    w[n-1] = 1'b1;
    return w;
  endfunction

  function automatic cword_t lit(input int v);
    cword_t w;
    w = '0;
    w[LIT_W-1:0] = LIT_W'(v);
    return w;
  endfunction

  function automatic cword_t img_word(input int a, input int jt);
    cword_t w;
    w = '0;
    if (a == 0)            w = cbit(15) | cbit(23);
    else if (a == 1)       w = cbit(21) | cbit(23);
    else if (a == 2)       w = cbit(25);
    else if (a == 3)       w = cbit(24) | lit(jt);
    else if (a == 4)       w = cbit(12) | cbit(24) | lit(0);
    else if (a == 5)       w = cbit(22) | cbit(23);
    else if (a == 6)       w = cbit(14) | cbit(26) | cbit(24) | lit(30);
    else if (a == 7)       w = cbit(24) | lit(9) | cbit(25) | cbit(23);
    else if (a == 8)       w = cbit(25) | cbit(23);
    else if (a == 9)       w = cbit(8);
    else if (a == 14)      w = cbit(9) | cbit(26);
    else if (a == jt)      w = cbit(10) | cbit(23);
    else if (a == jt + 1)  w = cbit(11) | cbit(23);
    else if (a == jt + 2)  w = cbit(13) | cbit(26);
    return w;
  endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int AW = 6,
  parameter int JT = 20
) (
  input  logic [AW-1:0] addr,
  output cword_t        word
);
  localparam int DEPTH = 2 ** AW;

  cword_t img [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_img
    assign img[i] = img_word(i, JT);
  end

  assign word = img[addr];
endmodule

// File: rtl/useq_opreg.sv
module useq_opreg #(
  parameter int OW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [OW-1:0] d,
  output logic [OW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end

  AST_OPC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> q == $past(d)); // R3
  AST_OPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q)); // R3
endmodule

// File: rtl/useq_next.sv
module useq_next #(
  parameter int AW = 6,
  parameter int OW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld_lit,
  input  logic          disp,
  input  logic          inc,
  input  logic [AW-1:0] lit,
  input  logic [OW-1:0] opc,
  output logic [AW-1:0] upc
);
  logic [AW-1:0] opc_ext;
  logic [AW-1:0] disp_tgt;
  logic [AW-1:0] upc_d;

  assign opc_ext  = AW'(opc);
  assign disp_tgt = upc + opc_ext + AW'(1);

  always_comb begin
    if (clr)         upc_d = '0;
    else if (ld_lit) upc_d = lit;
    else if (disp)   upc_d = disp_tgt;
    else if (inc)    upc_d = upc + AW'(1);
    else             upc_d = upc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= '0;
    else        upc <= upc_d;
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> upc == '0); // R6
  AST_LIT_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lit && !clr) |=> upc == $past(lit)); // R5
  AST_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (disp && !ld_lit && !clr) |=> upc == AW'($past(upc) + $past(opc_ext) + 1'b1)); // R4
  AST_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !disp && !ld_lit && !clr) |=> upc == AW'($past(upc) + 1'b1)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !disp && !ld_lit && !clr) |=> $stable(upc)); // R8
endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int AW = 6,
  parameter int JT = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   mem_opcode,
  output logic [DP_W-1:0] dp_cmd,
  output logic [AW-1:0]   upc,
  output logic [AW-1:0]   opcode
);
  cword_t word;

  useq_rom #(.AW(AW), .JT(JT)) rom_i (
    .addr (upc),
    .word (word)
  );

  useq_opreg #(.OW(AW)) opreg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (word[B_OPLD]),
    .d     (mem_opcode),
    .q     (opcode)
  );

  useq_next #(.AW(AW), .OW(AW)) next_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (word[B_CLR]),
    .ld_lit (word[B_LIT]),
    .disp   (word[B_DISP]),
    .inc    (word[B_INC]),
    .lit    (AW'(word[LIT_W-1:0])),
    .opc    (opcode),
    .upc    (upc)
  );

  assign dp_cmd = word[DP_LO +: DP_W];

  AST_BOOT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == '0) |-> dp_cmd[8]); // R11
endmodule

// File: tb/useq_core_tb_top.sv
module useq_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  mem_opcode = '0;
  logic [15:0] dp_cmd;
  logic [5:0]  upc;
  logic [5:0]  opcode;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  useq_core dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_opcode (mem_opcode),
    .dp_cmd     (dp_cmd),
    .upc        (upc),
    .opcode     (opcode)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [5:0] op);
    @(negedge clk);
    rst_n = 1'b0;
    mem_opcode = op;
    repeat (2) @(negedge clk);
    chk("R1", "upc in reset", int'(upc), 0);
    rst_n = 1'b1;
  endtask

  task automatic walk_to_dispatch(input logic [5:0] op);
    do_reset(op);
    step();
    step();
  endtask

  task automatic t_reset_state();
    do_reset(6'd0);
    chk("R1", "upc after reset", int'(upc), 0);
    chk("R1", "opcode after reset", int'(opcode), 0);
    chk("R9", "dp_cmd word0 C15", int'(dp_cmd), 16'h0100);
  endtask

  task automatic t_op0_path();
    do_reset(6'd0);
    step(); chk("R2", "inc to 1", int'(upc), 1);
    chk("R9", "dp_cmd word1 C21", int'(dp_cmd), 16'h4000);
    step(); chk("R2", "inc to 2", int'(upc), 2);
    step(); chk("R4", "dispatch op0", int'(upc), 3);
    step(); chk("R5", "literal jump", int'(upc), 20);
    chk("R9", "dp_cmd C10", int'(dp_cmd), 16'h0008);
    step(); chk("R2", "inc to 21", int'(upc), 21);
    chk("R9", "dp_cmd C11", int'(dp_cmd), 16'h0010);
    step(); chk("R9", "dp_cmd C13", int'(dp_cmd), 16'h0040);
    step(); chk("R6", "clear to 0", int'(upc), 0);
  endtask

  task automatic t_opcode_latch();
    do_reset(6'd1);
    step();
    step();
    mem_opcode = 6'd5;
    chk("R3", "opcode latched", int'(opcode), 1);
    step(); chk("R4", "dispatch op1", int'(upc), 4);
    chk("R3", "opcode held", int'(opcode), 1);
    chk("R9", "dp_cmd C12", int'(dp_cmd), 16'h0020);
    step(); chk("R5", "literal 0", int'(upc), 0);
  endtask

  task automatic t_priority();
    walk_to_dispatch(6'd2);
    step(); chk("R4", "dispatch op2", int'(upc), 5);
    chk("R9", "dp_cmd C22", int'(dp_cmd), 16'h8000);
    step(); chk("R2", "inc to 6", int'(upc), 6);
    step(); chk("R7", "clear beats literal", int'(upc), 0);
    walk_to_dispatch(6'd4);
    step(); chk("R4", "dispatch op4", int'(upc), 7);
    step(); chk("R7", "literal beats dispatch/inc", int'(upc), 9);
    chk("R9", "dp_cmd C8", int'(dp_cmd), 16'h0002);
    for (int k = 0; k < 3; k++) begin
      step(); chk("R8", "hold at 9", int'(upc), 9);
    end
    walk_to_dispatch(6'd5);
    step(); chk("R4", "dispatch op5", int'(upc), 8);
    step(); chk("R7", "dispatch beats inc", int'(upc), 14);
    chk("R9", "dp_cmd C9", int'(dp_cmd), 16'h0004);
    step(); chk("R6", "clear from 14", int'(upc), 0);
  endtask

  task automatic t_wrap();
    walk_to_dispatch(6'd62);
    chk("R3", "opcode 62", int'(opcode), 62);
    step(); chk("R10", "wrap to 1", int'(upc), 1);
    mem_opcode = 6'd2;
    step(); chk("R3", "reload opcode", int'(opcode), 2);
    step(); chk("R4", "dispatch after reload", int'(upc), 5);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_op0_path();
        t_opcode_latch();
        t_priority();
        t_wrap();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule